// File: doc/BRIEF.md
# Dithered High-Resolution PWM Generator

This block produces a single pulse-width-modulated output from a counter clocked at the core rate. The period and the high time are each given as an 11-bit whole number of clocks plus a 5-bit fraction. The fraction is realised by dithering over a frame of 32 PWM cycles: a carry accumulator picks a number of cycles in each frame, spread evenly, that run one clock longer. Over the frame, the average then resolves to 1/32 of a clock.

A static mode input selects which quantity is dithered. In variable-frequency mode the period fraction is used. Before use it is shifted left by a 3-bit scale input and saturated at 31. In variable-duty mode the period is a fixed whole number of clocks and the duty fraction is dithered instead.

Software reaches the two 16-bit settings through a byte-wide write port. A write to a high byte only fills a holding latch. The write to the matching low byte forms the full 16-bit word, and that word is taken into the running waveform at the next PWM cycle boundary.

Top module: `hrpwm_dither`

## Requirements
- R1: After reset the output is low and every setting, including both high-byte latches, is zero. A lone low-byte write therefore yields a value whose upper byte is 0x00.
- R2: Register slots are selected by bus_addr: 0 is the period high byte, 1 the period low byte, 2 the duty high byte and 3 the duty low byte. Each 16-bit word carries the whole-clock value in bits 15:5 and the fraction step in bits 4:0. A high-byte write alone changes nothing at the output. The low-byte write commits {latched high byte, low byte}.
- R3: A committed value takes effect only at the boundary between PWM cycles, and the current cycle finishes with the old settings. Both dither accumulators restart from zero when a value is taken, so the dither pattern restarts at frame position 0.
- R4: In variable-duty mode (vf_mode=0) every PWM cycle lasts exactly P clocks, whatever the period step and scale are.
- R5: In variable-frequency mode (vf_mode=1) the effective step is s = min(step << step_shift, 31). Cycle k after a commit (k counted from 0) lasts P+1 clocks when ((k*s) mod 32) + s >= 32, and P clocks otherwise. This gives exactly s long cycles in every 32.
- R6: In variable-duty mode, with duty step d, cycle k holds the output high for DC+1 clocks when ((k*d) mod 32) + d >= 32, and for DC clocks otherwise. The duty step is not scaled.
- R7: In variable-frequency mode the duty step is ignored, and every cycle is high for exactly DC clocks.
- R8: While the active whole-clock period is zero, the output stays low whatever the duty value is.
- R9: The output is high at the start of each cycle for its high count, then low for the rest of the cycle. A high count equal to or above the cycle length keeps the output high for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Byte write strobe, one clock per write |
| bus_addr | input | 2 | Register slot for the write |
| bus_wdata | input | 8 | Byte written |
| vf_mode | input | 1 | 1 = variable-frequency (period dithered), 0 = variable-duty (duty dithered) |
| step_shift | input | 3 | Left shift applied to the period step in variable-frequency mode |
| pwm_out | output | 1 | PWM waveform |

## Verification
The assertions assume that vf_mode and step_shift are static configuration, changed only while rst_n is low. They also assume that each write strobe lasts one clock and carries a valid slot. The bench keeps to this by setting both configuration inputs inside its reset sequence. It also issues every write as a single-clock pulse driven on the falling edge, and never overlaps two writes. Within those limits the bench sweeps every period step with several scales and every duty step. For each sweep it predicts the length and high time of each PWM cycle from the arithmetic in R5 and R6.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
    // Byte slots on the write port; bit 1 picks the register, bit 0 the byte.
    typedef enum logic [1:0] {
        SLOT_PER_HI  = 2'd0,
        SLOT_PER_LO  = 2'd1,
        SLOT_DUTY_HI = 2'd2,
        SLOT_DUTY_LO = 2'd3
    } slot_e;

    localparam int N_CHAN  = 2;
    localparam int CH_PER  = 0;
    localparam int CH_DUTY = 1;
endpackage

// File: rtl/hrp_shadow.sv
// High-byte holding latch plus committed 16-bit word and a pending flag.
module hrp_shadow #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [7:0]       wdata,
    input  logic             take,
    output logic [REG_W-1:0] staged,
    output logic             pend
);
    localparam int HOLD_W = REG_W - 8;

    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic [REG_W-1:0]  val;
        logic              pend;
    } shadow_t;

    shadow_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_hi) begin
            s_d.hold = HOLD_W'(wdata);
        end
        if (take) begin
            s_d.pend = 1'b0;
        end
        if (wr_lo) begin
            s_d.val  = {s_q.hold, wdata};
            s_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign staged = s_q.val;
    assign pend   = s_q.pend;
endmodule

// File: rtl/hrp_dither.sv
// Fractional carry accumulator: one carry per overflow of the frame modulus.
module hrp_dither #(
    parameter int FRAC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAC_W-1:0] step,
    input  logic              adv,
    input  logic              clr,
    output logic              carry,
    output logic [FRAC_W-1:0] acc
);
    typedef struct packed {
        logic [FRAC_W-1:0] acc;
    } dith_t;

    dith_t       d_d, d_q;
    logic [FRAC_W:0] sum;

    always_comb begin
        sum = {1'b0, d_q.acc} + {1'b0, step};
        d_d = d_q;
        if (clr) begin
            d_d.acc = '0;
        end else if (adv) begin
            d_d.acc = sum[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign carry = sum[FRAC_W];
    assign acc   = d_q.acc;
endmodule

// File: rtl/hrpwm_dither.sv
module hrpwm_dither #(
    parameter int INT_W  = 11,
    parameter int FRAC_W = 5,
    parameter int SEL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             vf_mode,
    input  logic [SEL_W-1:0] step_shift,
    output logic             pwm_out
);
    import hrp_pkg::*;

    localparam int REG_W     = INT_W + FRAC_W;
    localparam int CNT_W     = INT_W + 1;
    localparam int SHIFT_MAX = (1 << SEL_W) - 1;
    localparam int WIDE_W    = FRAC_W + SHIFT_MAX;

    typedef struct packed {
        logic [REG_W-1:0] per;
        logic [REG_W-1:0] duty;
        logic [CNT_W-1:0] cnt;
    } core_t;

    core_t st_d, st_q;

    logic [N_CHAN-1:0]             wr_hi, wr_lo, pend, carry;
    logic [N_CHAN-1:0][REG_W-1:0]  staged;
    logic [N_CHAN-1:0][FRAC_W-1:0] acc, step;
    logic                          wrap, load_any, adv;
    logic [INT_W-1:0]              per_int, duty_int;
    logic [WIDE_W-1:0]             wide;
    logic [FRAC_W-1:0]             per_scaled;
    logic [CNT_W-1:0]              cyc_len, hi_len;

    // Shadow latch and dither accumulator per channel (period, duty).
    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        assign wr_hi[g] = bus_we && (bus_addr == 2'(2 * g));
        assign wr_lo[g] = bus_we && (bus_addr == 2'(2 * g + 1));

        hrp_shadow #(.REG_W(REG_W)) u_shadow (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hi  (wr_hi[g]),
            .wr_lo  (wr_lo[g]),
            .wdata  (bus_wdata),
            .take   (wrap),
            .staged (staged[g]),
            .pend   (pend[g])
        );

        hrp_dither #(.FRAC_W(FRAC_W)) u_dither (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (step[g]),
            .adv   (adv),
            .clr   (load_any),
            .carry (carry[g]),
            .acc   (acc[g])
        );
    end

    always_comb begin
        per_int  = st_q.per[REG_W-1:FRAC_W];
        duty_int = st_q.duty[REG_W-1:FRAC_W];

        // Scaled, saturated period step.
        wide = WIDE_W'(st_q.per[FRAC_W-1:0]) << step_shift;
        if (|wide[WIDE_W-1:FRAC_W]) begin
            per_scaled = '1;
        end else begin
            per_scaled = wide[FRAC_W-1:0];
        end

        step[CH_PER]  = vf_mode ? per_scaled : '0;
        step[CH_DUTY] = vf_mode ? '0 : st_q.duty[FRAC_W-1:0];

        cyc_len = {1'b0, per_int} + CNT_W'(carry[CH_PER]);
        hi_len  = {1'b0, duty_int} + CNT_W'(carry[CH_DUTY]);

        wrap     = (per_int == '0) || (st_q.cnt == cyc_len - CNT_W'(1));
        load_any = wrap && (|pend);
        adv      = wrap && !load_any;

        st_d = st_q;
        if (wrap) begin
            st_d.cnt = '0;
            if (pend[CH_PER]) begin
                st_d.per = staged[CH_PER];
            end
            if (pend[CH_DUTY]) begin
                st_d.duty = staged[CH_DUTY];
            end
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_out = (per_int != '0) && (st_q.cnt < hi_len);

    // Named views for the bound checker.
    logic [REG_W-1:0]  act_per, act_duty, per_staged;
    logic [CNT_W-1:0]  cyc_cnt;
    logic [FRAC_W-1:0] per_acc;
    assign act_per    = st_q.per;
    assign act_duty   = st_q.duty;
    assign cyc_cnt    = st_q.cnt;
    assign per_staged = staged[CH_PER];
    assign per_acc    = acc[CH_PER];
endmodule

// File: rtl/hrp_checker.sv
module hrp_checker #(
    parameter int REG_W  = 16,
    parameter int FRAC_W = 5,
    parameter int CNT_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              pwm_out,
    input logic [REG_W-1:0]  act_per,
    input logic [REG_W-1:0]  act_duty,
    input logic [CNT_W-1:0]  cyc_cnt,
    input logic [REG_W-1:0]  per_staged,
    input logic [FRAC_W-1:0] per_acc
);
    logic [REG_W-FRAC_W-1:0] p_int, d_int;
    assign p_int = act_per[REG_W-1:FRAC_W];
    assign d_int = act_duty[REG_W-1:FRAC_W];

    // R2: high byte alone leaves the committed word untouched
    p_hi_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd0) |=> $stable(per_staged));

    // R2: low byte write lands in the committed word
    p_lo_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd1) |=> per_staged[7:0] == $past(bus_wdata));

    // R3: active period only changes when a new cycle starts
    p_load_at_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_per) |-> cyc_cnt == '0);

    // R3: accumulator restarts with a newly taken value
    p_acc_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_per) |-> per_acc == '0);

    // R4 / R5: counter never passes the longest legal cycle
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (p_int != '0) |-> cyc_cnt <= {1'b0, p_int});

    // R8: zero period keeps the output low
    p_zero_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (p_int == '0) |-> !pwm_out);

    // R9: duty beyond any cycle length keeps the output high
    p_full_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (p_int != '0 && d_int > p_int) |-> pwm_out);
endmodule

bind hrpwm_dither hrp_checker #(
    .REG_W  (REG_W),
    .FRAC_W (FRAC_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pwm_out    (pwm_out),
    .act_per    (act_per),
    .act_duty   (act_duty),
    .cyc_cnt    (cyc_cnt),
    .per_staged (per_staged),
    .per_acc    (per_acc)
);

// File: tb/sim_hrpwm_dither.sv
module sim_hrpwm_dither;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       vf_mode = 1'b0;
    logic [2:0] step_shift = 3'd0;
    logic       pwm_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    hrpwm_dither u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .vf_mode    (vf_mode),
        .step_shift (step_shift),
        .pwm_out    (pwm_out)
    );

    function automatic logic [15:0] pack(input int iv, input int st);
        return 16'((iv << 5) | st);
    endfunction

    task automatic bw(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_reset(input bit vf, input int sel);
        @(negedge clk);
        rst_n = 1'b0; vf_mode = vf; step_shift = 3'(sel);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Reset, write duty then period; returns at the edge the period is taken.
    task automatic setup(input int p, input int ps, input int dc, input int ds,
                         input bit vf, input int sel);
        logic [15:0] pv, dv;
        pv = pack(p, ps);
        dv = pack(dc, ds);
        do_reset(vf, sel);
        bw(2'd2, dv[15:8]); bw(2'd3, dv[7:0]);
        bw(2'd0, pv[15:8]); bw(2'd1, pv[7:0]);
        @(posedge clk);
    endtask

    // Predicts each PWM cycle from R5/R6/R7/R8/R9 and checks it clock by clock.
    task automatic expect_run(input string tag, input int p, input int dc,
                              input int ps, input int ds, input bit vf,
                              input int sel, input int ncyc);
        int sp, dstep;
        sp = vf ? (((ps << sel) > 31) ? 31 : (ps << sel)) : 0;
        dstep = vf ? 0 : ds;
        for (int k = 0; k < ncyc; k++) begin
            int  len, hi, bad_c;
            bit  lg, dl, bad, e, got;
            lg  = (((k * sp) % 32) + sp) >= 32;
            dl  = (((k * dstep) % 32) + dstep) >= 32;
            len = (p == 0) ? 1 : p + int'(lg);
            hi  = (p == 0) ? 0 : dc + int'(dl);
            bad = 1'b0; bad_c = 0; e = 1'b0; got = 1'b0;
            for (int c = 0; c < len; c++) begin
                @(negedge clk);
                if ((pwm_out !== (c < hi)) && !bad) begin
                    bad = 1'b1; bad_c = c; got = pwm_out; e = (c < hi);
                end
            end
            n_chk++;
            if (bad) begin
                n_fail++;
                $display("FAIL %s: cycle %0d clock %0d pwm=%b expected %b (len %0d high %0d)",
                         tag, k, bad_c, got, e, len, hi);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] nv;
        // R1: reset state low; lone low-byte writes see zeroed high latches
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_run("R1 reset low", 0, 0, 0, 0, 1'b0, 0, 20);
        bw(2'd3, 8'h20);                 // duty = 1
        bw(2'd1, 8'h60);                 // period = 3
        @(posedge clk);
        expect_run("R1 zero latch", 3, 1, 0, 0, 1'b0, 0, 8);

        // R2: high byte alone has no effect until the low byte arrives
        do_reset(1'b0, 0);
        bw(2'd2, 8'h00); bw(2'd3, 8'h40); // duty = 2
        bw(2'd0, 8'h01);                  // period high byte of 9
        expect_run("R2 hi held", 0, 0, 0, 0, 1'b0, 0, 60);
        bw(2'd1, 8'h20);
        @(posedge clk);
        expect_run("R2 commit", 9, 2, 0, 0, 1'b0, 0, 6);

        // R3: mid-cycle rewrite waits for the boundary (variable-duty)
        setup(40, 0, 10, 0, 1'b0, 0);
        fork
            begin
                expect_run("R3 old cycle", 40, 10, 0, 0, 1'b0, 0, 1);
                expect_run("R3 new value", 7, 3, 0, 0, 1'b0, 0, 6);
            end
            begin
                repeat (3) @(negedge clk);
                nv = pack(3, 0);
                bw(2'd2, nv[15:8]); bw(2'd3, nv[7:0]);
                nv = pack(7, 0);
                bw(2'd0, nv[15:8]); bw(2'd1, nv[7:0]);
            end
        join

        // R3: accumulator restarts on commit (variable-frequency)
        setup(30, 11, 2, 0, 1'b1, 0);
        fork
            begin
                expect_run("R3 old vf", 30, 2, 11, 0, 1'b1, 0, 1);
                expect_run("R3 acc restart", 5, 2, 11, 0, 1'b1, 0, 40);
            end
            begin
                repeat (2) @(negedge clk);
                nv = pack(5, 11);
                bw(2'd0, nv[15:8]); bw(2'd1, nv[7:0]);
            end
        join

        // R5 R7: every period step, duty step present but ignored
        for (int ps = 0; ps < 32; ps++) begin
            setup(4, ps, 2, 17, 1'b1, 0);
            expect_run("R5 R7 step sweep", 4, 2, ps, 17, 1'b1, 0, 64);
        end
        // R5: every scale, including saturation at 31
        for (int sel = 0; sel < 8; sel++) begin
            setup(6, 3, 6, 0, 1'b1, sel);
            expect_run("R5 scale sweep", 6, 6, 3, 0, 1'b1, sel, 64);
        end
        setup(1, 16, 0, 0, 1'b1, 0);
        expect_run("R5 one clock period", 1, 0, 16, 0, 1'b1, 0, 40);

        // R4 R6: every duty step, period step and scale present but ignored
        for (int ds = 0; ds < 32; ds++) begin
            setup(6, 9, 2, ds, 1'b0, 3);
            expect_run("R4 R6 duty sweep", 6, 2, 9, ds, 1'b0, 3, 64);
        end

        // R8: zero period stays low in both modes
        setup(0, 5, 7, 3, 1'b0, 0);
        expect_run("R8 zero vd", 0, 7, 5, 3, 1'b0, 0, 100);
        setup(0, 31, 7, 0, 1'b1, 7);
        expect_run("R8 zero vf", 0, 7, 31, 0, 1'b1, 7, 100);

        // R9: duty at or above cycle length stays high
        setup(10, 0, 10, 0, 1'b0, 0);
        expect_run("R9 equal", 10, 10, 0, 0, 1'b0, 0, 10);
        setup(5, 0, 2047, 31, 1'b0, 0);
        expect_run("R9 max duty", 5, 2047, 0, 31, 1'b0, 0, 10);
        setup(3, 31, 4, 0, 1'b1, 0);
        expect_run("R9 vf long", 3, 4, 31, 0, 1'b1, 0, 40);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule